// File: doc/BRIEF.md
# Two-Way Write-Through Data Cache

This block sits between a load/store stage and a byte-addressed backing memory and keeps a small set of recently used words close at hand. It holds sixteen one-word entries arranged as eight sets of two ways. Each entry is the little-endian word that starts at the entry's own byte address, so no alignment is imposed: any byte address can be cached. The low three address bits choose the set and the remaining 29 bits form the tag.

Loads come as whole words or as unsigned bytes, and stores come as whole words or as single bytes. A load that hits is answered from the cache in the cycle it is accepted. A load that misses is answered in the same cycle from the memory read port, and the fetched word is installed. Every store goes straight through to memory. Before the written bytes can go stale in the cache, any valid entry whose four-byte span overlaps them is dropped, and a word store then installs its own word. Each set keeps one recency bit that flips on every load hit, and new words go into the way that the bit does not point at.

The request side uses a valid/ready handshake. `req_ready` is high for a load that hits, and otherwise follows `mem_ready`, because misses and stores need the memory in the same cycle. While `req_valid` is high, the request fields must stay steady until the handshake. The response is not held back: `rsp_valid` pulses in the handshake cycle of each load.

Top module: `dcache_2way`

## Requirements
- R1: A synchronous reset clears every valid bit and every recency bit, so the first load accepted after reset misses.
- R2: A load hits only when a way of its set (address bits 2:0) is valid and holds the request's tag (address bits 31:3). An immediately repeated load of the same address always hits, and a load with a different tag in the same set misses.
- R3: A load that misses returns `mem_rdata` in its handshake cycle and installs that word, so every load returns the little-endian word at its byte address as memory holds it.
- R4: A byte load (`req_byte`=1) returns the byte at its address in bits 7:0 of `rsp_data`, with bits 31:8 zero, on hits and misses alike.
- R5: Each accepted store raises `mem_wr` in that same cycle with `mem_addr` equal to the request address. `mem_byte` follows `req_byte`, and `mem_wdata` carries the word, or the zero-extended low byte for a byte store.
- R6: A store invalidates every valid entry whose bytes (entry address to entry address + 3) overlap the written bytes, in any set. Entries that do not overlap keep hitting.
- R7: A word store installs its word at the store address, so a following word load of that address hits and returns the stored word.
- R8: Each set's recency bit inverts on every load hit. Fills from loads and word stores go to the way the bit does not select, and fills leave the bit unchanged.
- R9: `req_ready` is 1 for a load that hits whatever `mem_ready` is, and otherwise equals `mem_ready`. A request that is not accepted writes no memory, changes no cache state and produces no response.
- R10: `rsp_valid` is high exactly in the handshake cycle of a load, and `rsp_hit` is high only together with it when that load hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data (low byte used for byte stores) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| rsp_valid | output | 1 | Load data valid this cycle |
| rsp_data | output | 32 | Load data |
| rsp_hit | output | 1 | The responding load hit |
| mem_ready | input | 1 | Memory can serve an access this cycle |
| mem_rd | output | 1 | A load miss wants memory data |
| mem_wr | output | 1 | Write strobe to memory |
| mem_byte | output | 1 | Write covers one byte only |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Little-endian word at mem_addr, same cycle |

## Verification
A store can do two things to the cache in one cycle: it drops overlapping entries in other sets, and it installs a new word in its own set. It can even drop an entry and install in place of it in that same set. The bench sets this up by caching a word at one address and then storing a word three bytes below it. It then checks that the overlapped address misses with the fresh bytes and that the store address hits. Random mixes of loads and stores over a 64-byte window, with misaligned addresses and random memory stalls, judge every load against a byte-level copy of memory kept in the bench.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WAYS   = 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [WORD_W-1:0] word_t;

  // access kind, derived from the write and byte flags
  typedef enum logic [1:0] {
    ACC_LD_WORD = 2'b00,
    ACC_LD_BYTE = 2'b01,
    ACC_ST_WORD = 2'b10,
    ACC_ST_BYTE = 2'b11
  } acc_e;

  function automatic word_t zext_byte(input word_t w);
    return {{(WORD_W-BYTE_W){1'b0}}, w[BYTE_W-1:0]};
  endfunction

  // does a stored span [e, e+3] meet the written span [s, s+len-1]?
  function automatic logic spans_meet(input addr_t e, input addr_t s, input logic one_byte);
    addr_t fwd;
    addr_t back;
    fwd  = s - e;
    back = e - s;
    if (one_byte) return fwd < addr_t'(4);
    return (fwd < addr_t'(4)) || (back < addr_t'(4));
  endfunction
endpackage

// File: rtl/wtc_line_store.sv
module wtc_line_store
  import wtc_pkg::*;
#(
  parameter int unsigned SETS = 8,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned TAG_W = ADDR_W - IDX_W,
  localparam int unsigned ENT = SETS * WAYS
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [IDX_W-1:0]             look_set,
  output logic [WAYS-1:0]              look_valid,
  output logic [WAYS-1:0][TAG_W-1:0]   look_tag,
  output logic [WAYS-1:0][WORD_W-1:0]  look_word,
  output logic [ENT-1:0]               all_valid,
  output logic [ENT-1:0][ADDR_W-1:0]   all_addr,
  input  logic [ENT-1:0]               drop_mask,
  input  logic                         fill_en,
  input  logic [IDX_W-1:0]             fill_set,
  input  logic                         fill_way,
  input  logic [TAG_W-1:0]             fill_tag,
  input  logic [WORD_W-1:0]            fill_word
);
  logic [ENT-1:0]    valid_q;
  logic [TAG_W-1:0]  tag_q  [ENT];
  logic [WORD_W-1:0] word_q [ENT];

  logic [IDX_W:0] fill_ent;
  assign fill_ent = {fill_set, fill_way};

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_q & ~drop_mask;
      if (fill_en) valid_q[fill_ent] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_ent]  <= fill_tag;
      word_q[fill_ent] <= fill_word;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_look
    logic [IDX_W:0] le;
    assign le            = {look_set, w[0]};
    assign look_valid[w] = valid_q[le];
    assign look_tag[w]   = tag_q[le];
    assign look_word[w]  = word_q[le];
  end

  for (genvar e = 0; e < ENT; e++) begin : g_all
    localparam logic [IDX_W-1:0] SIDX = IDX_W'(e / WAYS);
    assign all_valid[e] = valid_q[e];
    assign all_addr[e]  = {tag_q[e], SIDX};
  end
endmodule

// File: rtl/wtc_span_scan.sv
module wtc_span_scan
  import wtc_pkg::*;
#(
  parameter int unsigned ENT = 16
) (
  input  logic [ENT-1:0]             ent_valid,
  input  logic [ENT-1:0][ADDR_W-1:0] ent_addr,
  input  logic [ADDR_W-1:0]          st_addr,
  input  logic                       st_byte,
  output logic [ENT-1:0]             meet_mask
);
  for (genvar e = 0; e < ENT; e++) begin : g_cmp
    assign meet_mask[e] = ent_valid[e] && spans_meet(ent_addr[e], st_addr, st_byte);
  end
endmodule

// File: rtl/wtc_recency.sv
module wtc_recency #(
  parameter int unsigned SETS = 8,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flip_en,
  input  logic [IDX_W-1:0] flip_set,
  input  logic [IDX_W-1:0] look_set,
  output logic             look_mru
);
  logic [SETS-1:0] mru_q;

  always_ff @(posedge clk) begin
    if (rst) mru_q <= '0;
    else if (flip_en) mru_q[flip_set] <= ~mru_q[flip_set];
  end

  assign look_mru = mru_q[look_set];
endmodule

// File: rtl/dcache_2way.sv
module dcache_2way
  import wtc_pkg::*;
#(
  parameter int unsigned SETS = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic        req_write,
  input  logic        req_byte,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        rsp_hit,
  input  logic        mem_ready,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic        mem_byte,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = ADDR_W - IDX_W;
  localparam int unsigned ENT   = SETS * WAYS;

  acc_e acc;
  assign acc = acc_e'({req_write, req_byte});

  logic [IDX_W-1:0] req_set;
  logic [TAG_W-1:0] req_tag;
  assign req_set = req_addr[IDX_W-1:0];
  assign req_tag = req_addr[ADDR_W-1:IDX_W];

  logic [WAYS-1:0]             look_valid;
  logic [WAYS-1:0][TAG_W-1:0]  look_tag;
  logic [WAYS-1:0][WORD_W-1:0] look_word;
  logic [ENT-1:0]              all_valid;
  logic [ENT-1:0][ADDR_W-1:0]  all_addr;
  logic [ENT-1:0]              meet_mask;
  logic [ENT-1:0]              drop_mask;
  logic                        mru;

  // way compare
  logic [WAYS-1:0] way_match;
  for (genvar w = 0; w < WAYS; w++) begin : g_match
    assign way_match[w] = look_valid[w] && (look_tag[w] == req_tag);
  end

  logic hit, hit_way, is_load, load_hit, fire;
  assign hit      = |way_match;
  assign hit_way  = way_match[1];
  assign is_load  = (acc == ACC_LD_WORD) || (acc == ACC_LD_BYTE);
  assign load_hit = is_load && hit;
  assign req_ready = load_hit || mem_ready;
  assign fire      = req_valid && req_ready;

  // load return path
  word_t load_word;
  assign load_word = hit ? look_word[hit_way] : mem_rdata;
  assign rsp_valid = fire && is_load;
  assign rsp_hit   = rsp_valid && hit;
  assign rsp_data  = (acc == ACC_LD_BYTE) ? zext_byte(load_word) : load_word;

  // memory side
  assign mem_rd    = req_valid && is_load && !hit;
  assign mem_wr    = fire && !is_load;
  assign mem_byte  = req_byte;
  assign mem_addr  = req_addr;
  assign mem_wdata = (acc == ACC_ST_BYTE) ? zext_byte(req_wdata) : req_wdata;

  // state updates
  logic fill_en;
  word_t fill_word;
  assign drop_mask = meet_mask & {ENT{fire && !is_load}};
  assign fill_en   = fire && ((is_load && !hit) || (acc == ACC_ST_WORD));
  assign fill_word = is_load ? mem_rdata : req_wdata;

  wtc_line_store #(.SETS(SETS)) u_store (
    .clk        (clk),
    .rst        (rst),
    .look_set   (req_set),
    .look_valid (look_valid),
    .look_tag   (look_tag),
    .look_word  (look_word),
    .all_valid  (all_valid),
    .all_addr   (all_addr),
    .drop_mask  (drop_mask),
    .fill_en    (fill_en),
    .fill_set   (req_set),
    .fill_way   (~mru),
    .fill_tag   (req_tag),
    .fill_word  (fill_word)
  );

  wtc_span_scan #(.ENT(ENT)) u_scan (
    .ent_valid (all_valid),
    .ent_addr  (all_addr),
    .st_addr   (req_addr),
    .st_byte   (req_byte),
    .meet_mask (meet_mask)
  );

  wtc_recency #(.SETS(SETS)) u_recency (
    .clk      (clk),
    .rst      (rst),
    .flip_en  (fire && load_hit),
    .flip_set (req_set),
    .look_set (req_set),
    .look_mru (mru)
  );
endmodule

// File: rtl/dcache_2way_checker.sv
module dcache_2way_checker (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic [31:0] req_wdata,
  input logic        req_write,
  input logic        req_byte,
  input logic        rsp_valid,
  input logic [31:0] rsp_data,
  input logic        rsp_hit,
  input logic        mem_ready,
  input logic        mem_wr,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_rdata
);
  logic fire;
  assign fire = req_valid && req_ready;

  // R1
  first_load_misses_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && fire && !req_write) |-> !rsp_hit);

  // R3
  miss_from_memory_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !req_write && !rsp_hit && !req_byte) |-> (rsp_data == mem_rdata));

  // R4
  byte_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && req_byte) |-> (rsp_data[31:8] == 24'h0));

  // R5
  store_through_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && req_write) |-> (mem_wr && mem_addr == req_addr));

  // R7
  store_then_hit_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(fire && req_write && !req_byte) && fire && !req_write && !req_byte
     && req_addr == $past(req_addr)) |-> (rsp_hit && rsp_data == $past(req_wdata)));

  // R9
  store_waits_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !mem_ready) |-> (!req_ready && !mem_wr));

  // R10
  rsp_only_on_load_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (req_valid && req_ready && !req_write));
endmodule

bind dcache_2way dcache_2way_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .req_write (req_write),
  .req_byte  (req_byte),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .rsp_hit   (rsp_hit),
  .mem_ready (mem_ready),
  .mem_wr    (mem_wr),
  .mem_addr  (mem_addr),
  .mem_rdata (mem_rdata)
);

// File: tb/dcache_2way_test.sv
`timescale 1ns/1ps
module dcache_2way_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, req_valid, req_ready, req_write, req_byte;
  logic [31:0] req_addr, req_wdata;
  logic        rsp_valid, rsp_hit, mem_ready, mem_rd, mem_wr, mem_byte;
  logic [31:0] rsp_data, mem_addr, mem_wdata, mem_rdata;

  dcache_2way uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .req_byte(req_byte), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_hit(rsp_hit), .mem_ready(mem_ready), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_byte(mem_byte), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // backing memory (256-byte window) and the bench's own copy
  logic [7:0] mem_b [256];
  logic [7:0] mirror [256];
  logic [7:0] mi;
  assign mi = mem_addr[7:0];
  assign mem_rdata = {mem_b[mi + 8'd3], mem_b[mi + 8'd2], mem_b[mi + 8'd1], mem_b[mi]};

  always @(posedge clk) begin
    if (mem_wr) begin
      mem_b[mi] <= mem_wdata[7:0];
      if (!mem_byte) begin
        mem_b[mi + 8'd1] <= mem_wdata[15:8];
        mem_b[mi + 8'd2] <= mem_wdata[23:16];
        mem_b[mi + 8'd3] <= mem_wdata[31:24];
      end
    end
  end

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit rnd_ready = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_word(input logic [31:0] a);
    logic [7:0] i;
    i = a[7:0];
    return {mirror[i + 8'd3], mirror[i + 8'd2], mirror[i + 8'd1], mirror[i]};
  endfunction

  // one access; waits for the handshake, checks data against the copy
  task automatic issue(input logic wr, input logic byt, input logic [31:0] a,
                       input logic [31:0] wd, output logic got_hit);
    logic [31:0] exp;
    logic [7:0] i;
    @(negedge clk);
    if (rnd_ready) mem_ready = 1'($urandom % 2);
    req_valid = 1'b1; req_write = wr; req_byte = byt; req_addr = a; req_wdata = wd;
    #1;
    while (!req_ready) begin
      check(!mem_wr && !rsp_valid, "R9", {30'b0, mem_wr, rsp_valid}, 32'h0);
      @(negedge clk);
      if (rnd_ready) mem_ready = 1'($urandom % 2);
      else mem_ready = 1'b1;
      #1;
    end
    got_hit = rsp_hit;
    if (!wr) begin
      exp = byt ? {24'h0, ref_word(a)[7:0]} : ref_word(a);
      check(rsp_valid, "R10", {31'b0, rsp_valid}, 32'h1);
      check(rsp_data == exp, byt ? "R4" : "R3", rsp_data, exp);
    end else begin
      exp = byt ? {24'h0, wd[7:0]} : wd;
      check(mem_wr && !rsp_valid && mem_addr == a && mem_byte == byt && mem_wdata == exp,
            "R5", mem_wdata, exp);
      i = a[7:0];
      mirror[i] = wd[7:0];
      if (!byt) begin
        mirror[i + 8'd1] = wd[15:8];
        mirror[i + 8'd2] = wd[23:16];
        mirror[i + 8'd3] = wd[31:24];
      end
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic expect_hit(input logic [31:0] a, input logic want, input string req);
    logic h;
    issue(1'b0, 1'b0, a, 32'h0, h);
    check(h == want, req, {31'b0, h}, {31'b0, want});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic h;
    for (int k = 0; k < 256; k++) begin
      mem_b[k] = 8'(k * 7 + 3);
      mirror[k] = 8'(k * 7 + 3);
    end
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_byte = 1'b0;
    req_addr = '0; req_wdata = '0; mem_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(!rsp_valid && !mem_wr, "R10", {30'b0, rsp_valid, mem_wr}, 32'h0);

    // R1 first load after reset misses; R2 repeat hits
    expect_hit(32'h10, 1'b0, "R1");
    expect_hit(32'h10, 1'b1, "R2");
    // R4 byte loads on a hit and on a miss
    issue(1'b0, 1'b1, 32'h10, 32'h0, h);
    check(h, "R4", {31'b0, h}, 32'h1);
    issue(1'b0, 1'b1, 32'h13, 32'h0, h);
    // R2 other tag, same set
    expect_hit(32'h18, 1'b0, "R2");

    // R5/R7 word store then hit
    issue(1'b1, 1'b0, 32'h40, 32'hCAFE_0123, h);
    expect_hit(32'h40, 1'b1, "R7");

    // R6 byte store overlapping a cached word
    expect_hit(32'h21, 1'b0, "R6");
    expect_hit(32'h21, 1'b1, "R6");
    issue(1'b1, 1'b1, 32'h23, 32'h0000_005A, h);
    expect_hit(32'h21, 1'b0, "R6");
    // word store 3 bytes below: drops 0x21 (set 1), installs 0x1E (set 6)
    issue(1'b1, 1'b0, 32'h1E, 32'h8765_4321, h);
    expect_hit(32'h21, 1'b0, "R6");
    expect_hit(32'h1E, 1'b1, "R7");
    // non-overlapping byte store leaves 0x21 (bytes 21..24) alone
    issue(1'b1, 1'b1, 32'h25, 32'h0000_00EE, h);
    expect_hit(32'h21, 1'b1, "R6");

    // R8 recency in set 5: A=0x85 B=0xA5 C=0xC5
    expect_hit(32'h85, 1'b0, "R8");
    expect_hit(32'h85, 1'b1, "R8");
    expect_hit(32'hA5, 1'b0, "R8");
    expect_hit(32'hC5, 1'b0, "R8");
    expect_hit(32'h85, 1'b1, "R8");
    expect_hit(32'hC5, 1'b1, "R8");
    expect_hit(32'hA5, 1'b0, "R8");
    expect_hit(32'h85, 1'b1, "R8");

    // R9 back-pressure
    @(negedge clk);
    mem_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_byte = 1'b0; req_addr = 32'h85;
    #1;
    check(req_ready && rsp_hit, "R9", {30'b0, req_ready, rsp_hit}, 32'h3);
    @(negedge clk);
    req_addr = 32'hE5;
    #1;
    check(!req_ready && !rsp_valid && mem_rd, "R9", {29'b0, req_ready, rsp_valid, mem_rd}, 32'h1);
    @(negedge clk);
    req_write = 1'b1; req_addr = 32'h85; req_wdata = 32'h1111_2222;
    #1;
    check(!req_ready && !mem_wr, "R9", {30'b0, req_ready, mem_wr}, 32'h0);
    @(negedge clk);
    req_write = 1'b0;
    #1;
    check(rsp_hit && rsp_data == ref_word(32'h85), "R9", rsp_data, ref_word(32'h85));
    @(negedge clk);
    req_valid = 1'b0;
    mem_ready = 1'b1;

    // sweep: every address in a 64-byte window, word then repeat
    for (int a = 0; a < 64; a++) begin
      issue(1'b0, 1'b0, 32'(a), 32'h0, h);
      expect_hit(32'(a), 1'b1, "R2");
    end

    // random mix with stalls
    rnd_ready = 1;
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ra;
      ra = 32'($urandom % 64);
      issue(1'($urandom % 3 == 0), 1'($urandom % 2), ra, $urandom, h);
    end
    rnd_ready = 0;
    mem_ready = 1'b1;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule